// File: doc/BRIEF.md
# Prioritized Interrupt Latch and Mask Controller

This controller decides which interrupt a processor core enters next. It keeps three registers. The request latch records pending hardware requests. The enable mask is written by software and also holds a global-enable bit. The in-service mask records which handlers are active and carries a global-disable marker for hardware nesting. Each cycle the controller looks for the lowest-indexed hardware request that is latched, enabled and not shadowed by an active handler. When it finds one and the global enable allows it, the controller raises an entry request and gives the vector index.

Software exceptions arrive as a one-cycle pulse. The pulse is issued when the faulting instruction reaches the second execute stage. The exception enters at once and aborts any hardware entry still in flight. It does not consume that entry's latched request. A hardware entry becomes final only when the handler's first instruction reaches the second execute stage. At that point edge requests are consumed and the global-disable marker is set. From then on no other hardware interrupt is accepted until the core reports that the return address has been saved. A return strobe retires the highest-priority active handler. The processor mode output follows the contents of the in-service mask.

Index map: bit 0 is the emulation exception, bit 1 the ordinary exception, and bits 2 to NUM_HW+1 are hardware lines 0 to NUM_HW-1. Bit NUM_HW+2 of both masks is the global bit. A lower index means a higher priority.

Top module: `irq_ctl`

## Requirements
- R1: After reset the latch, enable mask and in-service mask are all zero, `hw_req_o` is low and `mode_o` is 0 (user).
- R2: A line in edge mode (`edge_mode_i` bit 1) sets its latch bit on a rising transition, within four cycles. A line in level mode sets its latch bit while it is high and clears it while it is low.
- R3: `hw_req_o` rises only when the global enable bit is set. `hw_vec_o` is the lowest index that is latched, enabled and has no in-service bit at that index or below. A latched line whose enable bit is clear produces no request.
- R4: A `handler_ex2_i` strobe while `hw_req_o` is high commits the entry. The in-service bit of the vector and the global-disable marker are set, and `hw_req_o` drops. An edge-mode latch bit is cleared. A level-mode latch bit is left as it is.
- R5: While the global-disable marker is set and no `ret_saved_i` has followed the latest hardware commit, no hardware request is raised. After the strobe, only indices below the lowest active in-service bit may raise a request.
- R6: An `exc_i` pulse is accepted when `exc_emu_i` is 1, or when enable mask bit 1 is set. It sets in-service bit 0 (emulation) or bit 1 in the same edge, even when the global-disable marker is set, and it never sets the marker. An ordinary exception whose enable bit is clear leaves the in-service mask unchanged.
- R7: An accepted exception in the same cycle as `handler_ex2_i`, or while a hardware entry is pending, aborts that entry. The entry's in-service bit is not set and its latch bit stays set, so it is requested again once no longer blocked.
- R8: `ret_i` clears the lowest set in-service bit among the interrupt indices. It also clears the global-disable marker when no hardware in-service bit remains.
- R9: `mode_o` is 2 (emulation) while in-service bit 0 is set. It is 1 (supervisor) while any other interrupt in-service bit is set, and 0 (user) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_HW | Asynchronous hardware request lines |
| edge_mode_i | input | NUM_HW | Per line: 1 edge, 0 level |
| umask_we_i | input | 1 | Write strobe for the enable mask |
| umask_d_i | input | NUM_HW+3 | New enable mask value |
| exc_i | input | 1 | Exception pulse, issued at the second execute stage |
| exc_emu_i | input | 1 | Exception is an emulation exception |
| handler_ex2_i | input | 1 | First handler instruction reached the second execute stage |
| ret_saved_i | input | 1 | Return address saved by the handler |
| ret_i | input | 1 | Return from handler |
| hw_req_o | output | 1 | Hardware entry pending |
| hw_vec_o | output | clog2(NUM_HW+2) | Vector index of the pending entry |
| mode_o | output | 2 | 0 user, 1 supervisor, 2 emulation |
| latch_o | output | NUM_HW+2 | Request latch |
| umask_o | output | NUM_HW+3 | Enable mask |
| ism_o | output | NUM_HW+3 | In-service mask with global-disable marker on top |

## Verification
The risky coincidence is an accepted exception in the same cycle as the strobe that would commit a pending hardware entry. The bench builds up a pending edge request and then drives `exc_i` and `handler_ex2_i` on the same edge. It expects exactly the exception's in-service bit, no global-disable marker, and an intact latch bit. After the exception returns, the same vector must be requested again. A milder form of the abort, an exception while the entry is pending without the strobe, is judged the same way.

// File: rtl/irq_ctl_pkg.sv
// Shared constants and types for the interrupt controller.
// Assumes the fixed index map: emulation, exception, then hardware lines.
package irq_ctl_pkg;
    typedef enum logic [1:0] {
        MODE_USER = 2'd0,
        MODE_SUP  = 2'd1,
        MODE_EMU  = 2'd2
    } mode_e;

    localparam int unsigned EMU_IDX = 0;
    localparam int unsigned EXC_IDX = 1;
    localparam int unsigned HW_BASE = 2;
endpackage

// File: rtl/irq_ctl_sync.sv
// Per-line input conditioner: two-flop synchronizer plus a history flop.
// Gives the synchronized level and a one-cycle rising-edge pulse for each line.
// Assumes request lines are asynchronous and stay high at least two cycles.
module irq_ctl_sync #(
    parameter int NUM_HW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] irq_i,
    output logic [NUM_HW-1:0] level_o,
    output logic [NUM_HW-1:0] rise_o
);
    for (genvar j = 0; j < NUM_HW; j++) begin : g_line
        logic s1_q, s2_q, s3_q;

        // Shift the raw line through the synchronizer and history stages.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= irq_i[j];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end

        assign level_o[j] = s2_q;
        assign rise_o[j]  = s2_q & ~s3_q;
    end
endmodule

// File: rtl/irq_ctl_lsb.sv
// Lowest-set-bit finder: the fixed-priority pick (lowest index wins).
// Assumes IDX_W can hold W-1.
module irq_ctl_lsb #(
    parameter int W     = 8,
    parameter int IDX_W = 3
) (
    input  logic [W-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so the lowest set index is written last.
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |vec_i;
endmodule

// File: rtl/irq_ctl.sv
// Interrupt latch, enable mask and in-service mask with fixed priority.
// Raises a hardware entry request, commits it when the handler reaches the
// second execute stage, lets accepted exceptions pre-empt it, and retires
// handlers on return. Assumes strobes are one cycle wide and synchronous.
module irq_ctl
    import irq_ctl_pkg::*;
#(
    parameter  int NUM_HW  = 6,
    localparam int NUM_IDX = NUM_HW + 2,
    localparam int MW      = NUM_IDX + 1,
    localparam int IDX_W   = $clog2(NUM_IDX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] irq_i,
    input  logic [NUM_HW-1:0] edge_mode_i,
    input  logic              umask_we_i,
    input  logic [MW-1:0]     umask_d_i,
    input  logic              exc_i,
    input  logic              exc_emu_i,
    input  logic              handler_ex2_i,
    input  logic              ret_saved_i,
    input  logic              ret_i,
    output logic              hw_req_o,
    output logic [IDX_W-1:0]  hw_vec_o,
    output logic [1:0]        mode_o,
    output logic [NUM_IDX-1:0] latch_o,
    output logic [MW-1:0]     umask_o,
    output logic [MW-1:0]     ism_o
);
    localparam int GBIT = NUM_IDX;

    logic [NUM_HW-1:0]  lvl, rise;
    logic [NUM_HW-1:0]  latch_hw_q;
    logic [NUM_IDX-1:0] latch_q;
    logic [MW-1:0]      umask_q, ism_q, ism_n;
    logic               pend_q, saved_q;
    logic [IDX_W-1:0]   pend_idx_q;
    logic               exc_take, commit, gate, run;
    logic [IDX_W-1:0]   exc_idx;
    logic [NUM_IDX-1:0] elig;
    logic               elig_any, ism_any;
    logic [IDX_W-1:0]   elig_idx, ism_low;
    mode_e              mode;

    irq_ctl_sync #(.NUM_HW(NUM_HW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (irq_i),
        .level_o (lvl),
        .rise_o  (rise)
    );

    // Accept decisions for this cycle.
    assign exc_take = exc_i & (exc_emu_i | umask_q[EXC_IDX]);
    assign exc_idx  = exc_emu_i ? IDX_W'(EMU_IDX) : IDX_W'(EXC_IDX);
    assign commit   = pend_q & handler_ex2_i & ~exc_take;
    assign gate     = umask_q[GBIT] & ~(ism_q[GBIT] & ~saved_q);

    // Request latch, one flop per hardware line, edge or level behaviour.
    for (genvar j = 0; j < NUM_HW; j++) begin : g_latch
        localparam int LI = HW_BASE + j;
        always_ff @(posedge clk) begin
            if (!rst_n)
                latch_hw_q[j] <= 1'b0;
            else if (!edge_mode_i[j])
                latch_hw_q[j] <= lvl[j];
            else if (rise[j])
                latch_hw_q[j] <= 1'b1;
            else if (commit && pend_idx_q == IDX_W'(LI))
                latch_hw_q[j] <= 1'b0;
        end
    end
    assign latch_q = {latch_hw_q, {HW_BASE{1'b0}}};

    // Eligibility: latched, enabled, not shadowed by an active handler, gated.
    always_comb begin
        run  = 1'b0;
        elig = '0;
        for (int i = 0; i < NUM_IDX; i++) begin
            run = run | ism_q[i];
            if (i >= int'(HW_BASE))
                elig[i] = latch_q[i] & umask_q[i] & ~run & gate;
        end
    end

    irq_ctl_lsb #(.W(NUM_IDX), .IDX_W(IDX_W)) u_pick (
        .vec_i (elig),
        .any_o (elig_any),
        .idx_o (elig_idx)
    );

    irq_ctl_lsb #(.W(NUM_IDX), .IDX_W(IDX_W)) u_retire (
        .vec_i (ism_q[NUM_IDX-1:0]),
        .any_o (ism_any),
        .idx_o (ism_low)
    );

    // Pending hardware entry: issue, then commit or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
        end else if (exc_take || commit) begin
            pend_q     <= 1'b0;
        end else if (!pend_q && elig_any) begin
            pend_q     <= 1'b1;
            pend_idx_q <= elig_idx;
        end
    end

    // Next in-service mask: retire on return, then set on entry.
    always_comb begin
        ism_n = ism_q;
        if (ret_i && ism_any) begin
            ism_n[ism_low] = 1'b0;
            if (!(|ism_n[NUM_IDX-1:HW_BASE])) ism_n[GBIT] = 1'b0;
        end
        if (commit) begin
            ism_n[pend_idx_q] = 1'b1;
            ism_n[GBIT]       = 1'b1;
        end
        if (exc_take) ism_n[exc_idx] = 1'b1;
    end

    // In-service mask, saved-return flag and enable mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ism_q   <= '0;
            saved_q <= 1'b0;
            umask_q <= '0;
        end else begin
            ism_q <= ism_n;
            if (commit)           saved_q <= 1'b0;
            else if (ret_saved_i) saved_q <= 1'b1;
            if (umask_we_i)       umask_q <= umask_d_i;
        end
    end

    // Processor mode from the active handlers.
    always_comb begin
        if (ism_q[EMU_IDX])              mode = MODE_EMU;
        else if (|ism_q[NUM_IDX-1:0])    mode = MODE_SUP;
        else                             mode = MODE_USER;
    end

    assign hw_req_o = pend_q;
    assign hw_vec_o = pend_idx_q;
    assign mode_o   = mode;
    assign latch_o  = latch_q;
    assign umask_o  = umask_q;
    assign ism_o    = ism_q;
endmodule

// File: rtl/irq_ctl_chk.sv
// Property checker for irq_ctl, attached by bind below.
// Observes accept decisions, pending state and the in-service mask.
module irq_ctl_chk #(
    parameter  int NUM_HW  = 6,
    localparam int NUM_IDX = NUM_HW + 2,
    localparam int MW      = NUM_IDX + 1,
    localparam int IDX_W   = $clog2(NUM_IDX),
    localparam int GBIT    = NUM_IDX
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_take,
    input logic             commit,
    input logic             pend_q,
    input logic [IDX_W-1:0] pend_idx_q,
    input logic             saved_q,
    input logic             ism_any,
    input logic             ret_i,
    input logic [MW-1:0]    ism_q,
    input logic [MW-1:0]    umask_q
);
    p_commit_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ism_q[GBIT] && ism_q[$past(pend_idx_q)]);

    p_hold_until_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ism_q[GBIT] && !saved_q) |-> !pend_q);

    p_req_needs_global_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(umask_q[GBIT]));

    p_exc_no_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && !ism_q[GBIT]) |=> !ism_q[GBIT]);

    p_exc_aborts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && pend_q) |=> !pend_q);

    p_ret_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && ism_any && !exc_take && !commit) |=>
        $countones(ism_q[NUM_IDX-1:0]) == $past($countones(ism_q[NUM_IDX-1:0])) - 1);
endmodule

bind irq_ctl irq_ctl_chk #(.NUM_HW(NUM_HW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_take   (exc_take),
    .commit     (commit),
    .pend_q     (pend_q),
    .pend_idx_q (pend_idx_q),
    .saved_q    (saved_q),
    .ism_any    (ism_any),
    .ret_i      (ret_i),
    .ism_q      (ism_q),
    .umask_q    (umask_q)
);

// File: tb/irq_ctl_tb.sv
// Directed sweep bench for irq_ctl with six hardware lines.
module irq_ctl_tb_top;
    localparam int NUM_HW = 6;
    localparam int NI     = NUM_HW + 2;
    localparam int MW     = NI + 1;
    localparam int G      = 1 << NI;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_HW-1:0] irq = '0;
    logic [NUM_HW-1:0] emode = '1;
    logic              we = 1'b0;
    logic [MW-1:0]     wd = '0;
    logic              exc = 1'b0, emu = 1'b0, ex2 = 1'b0, saved = 1'b0, ret = 1'b0;
    logic              req;
    logic [2:0]        vec;
    logic [1:0]        mode;
    logic [NI-1:0]     latch;
    logic [MW-1:0]     umask, ism;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_ctl #(.NUM_HW(NUM_HW)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .edge_mode_i(emode),
        .umask_we_i(we), .umask_d_i(wd), .exc_i(exc), .exc_emu_i(emu),
        .handler_ex2_i(ex2), .ret_saved_i(saved), .ret_i(ret),
        .hw_req_o(req), .hw_vec_o(vec), .mode_o(mode), .latch_o(latch),
        .umask_o(umask), .ism_o(ism)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_mask(input int v);
        we = 1'b1; wd = MW'(v); tick(1); we = 1'b0;
    endtask
    task automatic p_ex2();   ex2 = 1'b1;   tick(1); ex2 = 1'b0;   endtask
    task automatic p_saved(); saved = 1'b1; tick(1); saved = 1'b0; endtask
    task automatic p_ret();   ret = 1'b1;   tick(1); ret = 1'b0;   endtask
    task automatic p_exc(input logic e);
        exc = 1'b1; emu = e; tick(1); exc = 1'b0; emu = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 latch", int'(latch), 0);
        check("R1 ism", int'(ism), 0);
        check("R1 umask", int'(umask), 0);
        check("R1 req", int'(req), 0);
        check("R1 mode", int'(mode), 0);

        // R2/R3/R4/R8 sweep over every edge line
        set_mask(G | 'hFC);
        for (int j = 0; j < NUM_HW; j++) begin
            irq[j] = 1'b1; tick(6);
            check("R2 edge latch", int'(latch), 1 << (j + 2));
            check("R3 req", int'(req), 1);
            check("R3 vec", int'(vec), j + 2);
            p_ex2();
            check("R4 edge cleared", int'(latch), 0);
            check("R4 ism", int'(ism), G | (1 << (j + 2)));
            check("R9 mode sup", int'(mode), 1);
            check("R4 req drop", int'(req), 0);
            irq[j] = 1'b0;
            p_saved(); p_ret();
            check("R8 ism cleared", int'(ism), 0);
            check("R9 mode user", int'(mode), 0);
        end

        // R3 global enable and per-line enable
        set_mask('hFC);
        irq[0] = 1'b1; tick(6);
        check("R3 global off latch", int'(latch), 'h04);
        check("R3 global off req", int'(req), 0);
        set_mask(G | 'hF8); tick(2);
        check("R3 line disabled req", int'(req), 0);
        set_mask(G | 'hFC); tick(2);
        check("R3 enabled vec", int'(vec), 2);
        check("R3 enabled req", int'(req), 1);
        p_ex2(); irq[0] = 1'b0; p_saved(); p_ret();

        // R5 priority, blocking until saved, nesting
        irq[1] = 1'b1; irq[4] = 1'b1; tick(6);
        check("R3 priority vec", int'(vec), 3);
        p_ex2();
        check("R4 ism first", int'(ism), G | 'h08);
        irq[0] = 1'b1; tick(6);
        check("R5 latch", int'(latch), 'h44);
        check("R5 blocked before save", int'(req), 0);
        p_saved(); tick(2);
        check("R5 nest req", int'(req), 1);
        check("R5 nest vec", int'(vec), 2);
        p_ex2();
        check("R5 nested ism", int'(ism), G | 'h0C);
        p_saved(); tick(3);
        check("R5 lower prio blocked", int'(req), 0);
        p_ret();
        check("R8 inner retired", int'(ism), G | 'h08);
        tick(2);
        check("R5 still blocked", int'(req), 0);
        p_ret();
        check("R8 marker cleared", int'(ism), 0);
        tick(2);
        check("R5 released vec", int'(vec), 6);
        irq = '0;
        p_ex2(); p_saved(); p_ret();
        check("R4 all consumed", int'(latch), 0);

        // R2/R4 level mode line
        emode[2] = 1'b0; irq[2] = 1'b1; tick(6);
        check("R2 level latch", int'(latch), 'h10);
        check("R3 level vec", int'(vec), 4);
        p_ex2();
        check("R4 level kept", int'(latch), 'h10);
        check("R4 level ism", int'(ism), G | 'h10);
        irq[2] = 1'b0; tick(4);
        check("R2 level follows", int'(latch), 0);
        p_saved(); p_ret(); emode = '1;

        // R6 exceptions not blocked by the marker, no marker set
        set_mask(G | 'hFE);
        irq[3] = 1'b1; tick(6); p_ex2(); irq[3] = 1'b0;
        p_exc(1'b0);
        check("R6 exc over marker", int'(ism), G | 'h22);
        check("R9 exc mode", int'(mode), 1);
        p_ret();
        check("R8 exc retired first", int'(ism), G | 'h20);
        p_ret();
        check("R8 hw retired", int'(ism), 0);
        set_mask(G | 'hFC);
        p_exc(1'b1);
        check("R6 emu entry", int'(ism), 'h01);
        check("R6 emu no marker", int'(ism[NI]), 0);
        check("R9 emu mode", int'(mode), 2);
        p_ret();
        check("R9 back to user", int'(mode), 0);
        p_exc(1'b0);
        check("R6 disabled exc ignored", int'(ism), 0);

        // R7 collision of exception and commit strobe
        set_mask(G | 'hFE);
        irq[3] = 1'b1; tick(6);
        check("R7 pending vec", int'(vec), 5);
        irq[3] = 1'b0;
        exc = 1'b1; ex2 = 1'b1; tick(1); exc = 1'b0; ex2 = 1'b0;
        check("R7 only exc in service", int'(ism), 'h02);
        check("R7 latch kept", int'(latch), 'h20);
        check("R7 req dropped", int'(req), 0);
        p_ret(); tick(2);
        check("R7 reissued req", int'(req), 1);
        check("R7 reissued vec", int'(vec), 5);
        p_ex2();
        check("R7 reentered", int'(ism), G | 'h20);
        p_saved(); p_ret();

        // R7 abort while pending without commit strobe
        irq[5] = 1'b1; tick(6);
        check("R7 pending7", int'(vec), 7);
        irq[5] = 1'b0;
        p_exc(1'b0);
        check("R7 abort ism", int'(ism), 'h02);
        check("R7 abort latch", int'(latch), 'h80);
        p_ret(); tick(2);
        check("R7 abort reissue", int'(vec), 7);
        p_ex2(); p_saved(); p_ret();
        check("R8 final ism", int'(ism), 0);
        check("R4 final latch", int'(latch), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule